// File: doc/BRIEF.md
# Cache Miss Sampling Unit

This unit observes a stream of data-cache miss events, each arriving with the address that missed. It counts the misses down from a programmable period. When the count runs out, it latches the address of the miss that ended the count and raises an interrupt. A handler reads the latched address, looks up the data object that contains it, and bumps a per-object counter. Over many samples, this builds a statistical profile of which data structures cause misses.

A loop that walks memory with a fixed stride can phase-lock with a fixed sampling period, so that the same few variables are always chosen. To avoid this, each new interval can be stretched by a pseudo-random amount. A 16-bit linear feedback shift register supplies the amount. The register output is masked to a configurable number of low bits and added to the base period each time the counter reloads.

A three-state controller sequences the block. The states are OFF (period is zero), RUN (counting, no interrupt pending) and HELD (interrupt pending). The transitions are:
- ENABLE: OFF to RUN, when the period becomes nonzero.
- SAMPLE: RUN to HELD, when the count expires.
- RELEASE: HELD to RUN, on an acknowledge that does not coincide with a new sample.
- RESAMPLE: HELD to HELD, on a sample with or without an acknowledge.
- DISABLE: any state to OFF, when the period is zero.

Top module: `miss_sampler`

## Requirements
- R1: After reset, `irq` and `overflow` are 0 and `sample_addr` is 0.
- R2: With jitter disabled and period n > 0, `irq` rises on the clock edge that registers the n-th counted miss after enabling or after the previous sample point. Counting begins on the cycle after the period becomes nonzero, and continues while an interrupt is pending.
- R3: `sample_addr` takes the address of the miss that caused the sample. It is not changed by any other miss while `irq` is pending.
- R4: `irq` stays high until `irq_ack` is asserted. An acknowledge that does not coincide with a sample point clears both `irq` and `overflow` on the next edge.
- R5: A sample point that occurs while `irq` is pending and is not acknowledged in that cycle sets `overflow` and leaves `sample_addr` unchanged.
- R6: A sample point in the same cycle as `irq_ack` keeps `irq` high, captures the new miss address and clears `overflow`.
- R7: A period of 0 disables sampling: `irq` and `overflow` drop on the next edge and no interrupt is raised. The count restarts from a fresh reload when the period becomes nonzero again.
- R8: With jitter enabled and jitter width w (0..16), every interval lies between n and n + 2^w − 1 misses. With w = 0 it is exactly n. For w > 0, the intervals vary from sample to sample.
- R9: Cycles with `miss_valid` low are not counted, whatever the value on `miss_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | A data-cache miss occurs this cycle |
| miss_addr | input | ADDR_W | Address of that miss |
| cfg_period | input | CNT_W | Base sampling period in misses; 0 disables |
| cfg_jitter_en | input | 1 | Add pseudo-random jitter to each reload |
| cfg_jitter_bits | input | 5 | Number of low jitter bits used (0..16) |
| irq_ack | input | 1 | Acknowledge of the pending sample |
| irq | output | 1 | Sample interrupt, level, held until acknowledged |
| sample_addr | output | ADDR_W | Captured miss address |
| overflow | output | 1 | A further sample point occurred before the acknowledge |

## Verification
A sample point and an acknowledge can fall in the same cycle. So can a sample point and a still-pending interrupt. The bench provokes the first case by running the count to within one miss of expiry while an interrupt is pending, then driving the last miss together with `irq_ack`. It expects `irq` to remain set, `sample_addr` to hold the new address and `overflow` to be clear. It provokes the second case by letting a full further period elapse without an acknowledge. It expects `overflow` set and the first captured address retained.

// File: rtl/miss_sampler_pkg.sv
package miss_sampler_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HELD = 2'd2
    } samp_state_t;

    localparam int JIT_W = 16;
    localparam int JIT_SEL_W = $clog2(JIT_W + 1);
    localparam logic [JIT_W-1:0] LFSR_TAPS = 16'hB400;

endpackage

// File: rtl/ms_jitter_lfsr.sv
module ms_jitter_lfsr
    import miss_sampler_pkg::*;
#(
    parameter logic [JIT_W-1:0] SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [JIT_W-1:0] value
);

    logic [JIT_W-1:0] state_q;
    logic [JIT_W-1:0] state_d;

    always_comb begin
        state_d = state_q >> 1;
        if (state_q[0]) begin
            state_d = state_d ^ LFSR_TAPS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (step) begin
            state_q <= state_d;
        end
    end

    assign value = state_q;

endmodule

// File: rtl/ms_reload_calc.sv
module ms_reload_calc
    import miss_sampler_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0]     period,
    input  logic                 jitter_en,
    input  logic [JIT_SEL_W-1:0] jitter_bits,
    input  logic [JIT_W-1:0]     rnd,
    output logic [CNT_W-1:0]     reload
);

    localparam int PAD_W = CNT_W + 1 - JIT_W;

    logic [JIT_W-1:0] mask;
    logic [JIT_W-1:0] jit;
    logic [CNT_W:0]   sum;

    for (genvar i = 0; i < JIT_W; i++) begin : g_mask
        assign mask[i] = (JIT_SEL_W'(i) < jitter_bits);
    end

    always_comb begin
        jit    = jitter_en ? (rnd & mask) : '0;
        sum    = {1'b0, period} + {{PAD_W{1'b0}}, jit};
        reload = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    end

endmodule

// File: rtl/ms_countdown.sv
module ms_countdown #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             active,
    input  logic             miss,
    input  logic [CNT_W-1:0] reload,
    output logic             hit
);

    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last = (cnt_q <= CNT_W'(1));
    assign hit  = active && miss && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (arm) begin
            cnt_q <= reload;
        end else if (active && miss) begin
            cnt_q <= last ? reload : (cnt_q - CNT_W'(1));
        end
    end

endmodule

// File: rtl/miss_sampler.sv
module miss_sampler
    import miss_sampler_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32,
    parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 miss_valid,
    input  logic [ADDR_W-1:0]    miss_addr,
    input  logic [CNT_W-1:0]     cfg_period,
    input  logic                 cfg_jitter_en,
    input  logic [JIT_SEL_W-1:0] cfg_jitter_bits,
    input  logic                 irq_ack,
    output logic                 irq,
    output logic [ADDR_W-1:0]    sample_addr,
    output logic                 overflow
);

    samp_state_t state_q;
    samp_state_t state_d;

    logic             period_nz;
    logic             arm;
    logic             active;
    logic             hit;
    logic             step;
    logic [JIT_W-1:0] rnd;
    logic [CNT_W-1:0] reload;

    logic              irq_q;
    logic              ovf_q;
    logic [ADDR_W-1:0] addr_q;

    assign period_nz = (cfg_period != '0);
    assign arm       = (state_q == ST_OFF) && period_nz;
    assign active    = (state_q != ST_OFF) && period_nz;
    assign step      = arm || hit;

    ms_jitter_lfsr #(
        .SEED (LFSR_SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .value (rnd)
    );

    ms_reload_calc #(
        .CNT_W (CNT_W)
    ) u_reload (
        .period      (cfg_period),
        .jitter_en   (cfg_jitter_en),
        .jitter_bits (cfg_jitter_bits),
        .rnd         (rnd),
        .reload      (reload)
    );

    ms_countdown #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm),
        .active (active),
        .miss   (miss_valid),
        .reload (reload),
        .hit    (hit)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (period_nz) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!period_nz) state_d = ST_OFF;
                else if (hit)   state_d = ST_HELD;
            end
            ST_HELD: begin
                if (!period_nz)          state_d = ST_OFF;
                else if (irq_ack && !hit) state_d = ST_RUN;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            ovf_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    irq_q <= 1'b0;
                    ovf_q <= 1'b0;
                end
                ST_RUN: begin
                    if (!period_nz) begin
                        irq_q <= 1'b0;
                        ovf_q <= 1'b0;
                    end else if (hit) begin
                        irq_q  <= 1'b1;
                        addr_q <= miss_addr;
                    end
                end
                ST_HELD: begin
                    if (!period_nz) begin
                        irq_q <= 1'b0;
                        ovf_q <= 1'b0;
                    end else if (hit && irq_ack) begin
                        addr_q <= miss_addr;
                        ovf_q  <= 1'b0;
                    end else if (hit) begin
                        ovf_q <= 1'b1;
                    end else if (irq_ack) begin
                        irq_q <= 1'b0;
                        ovf_q <= 1'b0;
                    end
                end
                default: begin
                    irq_q <= 1'b0;
                    ovf_q <= 1'b0;
                end
            endcase
        end
    end

    assign irq         = irq_q;
    assign overflow    = ovf_q;
    assign sample_addr = addr_q;

endmodule

// File: rtl/miss_sampler_checker.sv
module miss_sampler_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic [ADDR_W-1:0] miss_addr,
    input logic [CNT_W-1:0]  cfg_period,
    input logic              irq_ack,
    input logic              irq,
    input logic [ADDR_W-1:0] sample_addr,
    input logic              overflow
);

    // R2: an interrupt only ever rises on an edge that registered a miss
    p_rise_on_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(miss_valid));

    // R3: the rising interrupt carries the address of that miss
    p_capture_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (sample_addr == $past(miss_addr)));

    // R3: no acknowledge means the captured address is held
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> $stable(sample_addr));

    // R4: the interrupt is held until acknowledged
    p_irq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack && cfg_period != '0) |=> irq);

    // R4: an acknowledge with no miss that cycle clears the interrupt
    p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_ack && !miss_valid) |=> (!irq && !overflow));

    // R5: overflow only accompanies a pending interrupt
    p_ovf_with_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> irq);

    // R7: a zero period drops the interrupt
    p_off_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_period == '0) |=> (!irq && !overflow));

endmodule

bind miss_sampler miss_sampler_checker #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .miss_valid  (miss_valid),
    .miss_addr   (miss_addr),
    .cfg_period  (cfg_period),
    .irq_ack     (irq_ack),
    .irq         (irq),
    .sample_addr (sample_addr),
    .overflow    (overflow)
);

// File: tb/miss_sampler_test.sv
module miss_sampler_test;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              miss_valid = 1'b0;
    logic [ADDR_W-1:0] miss_addr = '0;
    logic [CNT_W-1:0]  cfg_period = '0;
    logic              cfg_jitter_en = 1'b0;
    logic [4:0]        cfg_jitter_bits = '0;
    logic              irq_ack = 1'b0;
    logic              irq;
    logic [ADDR_W-1:0] sample_addr;
    logic              overflow;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #5 clk = ~clk;

    miss_sampler #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .miss_valid      (miss_valid),
        .miss_addr       (miss_addr),
        .cfg_period      (cfg_period),
        .cfg_jitter_en   (cfg_jitter_en),
        .cfg_jitter_bits (cfg_jitter_bits),
        .irq_ack         (irq_ack),
        .irq             (irq),
        .sample_addr     (sample_addr),
        .overflow        (overflow)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one counted miss; returns at the negedge after the registering edge
    task automatic do_miss(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        miss_valid = 1'b1;
        miss_addr  = a;
        @(negedge clk);
        miss_valid = 1'b0;
    endtask

    task automatic miss_with_ack(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        miss_valid = 1'b1;
        irq_ack    = 1'b1;
        miss_addr  = a;
        @(negedge clk);
        miss_valid = 1'b0;
        irq_ack    = 1'b0;
    endtask

    task automatic idle(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        miss_addr = a;
    endtask

    task automatic ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic set_period(input logic [CNT_W-1:0] p);
        @(negedge clk);
        cfg_period = p;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] a;
        int cnt, mn, mx;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(irq == 1'b0, "R1", irq, 0);
        check(overflow == 1'b0, "R1", overflow, 0);
        check(sample_addr == '0, "R1", sample_addr, 0);
        rst_n = 1'b1;

        // R2/R3/R9 sweep of periods with jitter disabled
        for (int n = 1; n <= 6; n++) begin
            set_period('0);
            set_period(CNT_W'(n));
            for (int k = 1; k <= 3 * n; k++) begin
                a = 32'hA000_0000 + (n << 16) + k * 4;
                if (k % 2 == 0) idle(32'hDEAD_0000 + k); // R9 invalid cycles
                do_miss(a);
                check(irq == (k % n == 0), "R2", irq, (k % n == 0));
                if (k % n == 0) begin
                    check(sample_addr == a, "R3", sample_addr, a);
                    ack();
                    check(irq == 1'b0, "R4", irq, 0);
                end
            end
        end

        // R9: long stretch of invalid cycles does not advance the count
        set_period('0);
        set_period(32'd3);
        do_miss(32'h10);
        do_miss(32'h14);
        for (int i = 0; i < 20; i++) idle(32'h5000 + i);
        check(irq == 1'b0, "R9", irq, 0);
        do_miss(32'h18);
        check(irq == 1'b1, "R9", irq, 1);

        // R4 hold, then R3/R5 overflow without ack
        for (int i = 0; i < 5; i++) idle(32'h0);
        check(irq == 1'b1, "R4", irq, 1);
        do_miss(32'h20);
        do_miss(32'h24);
        check(overflow == 1'b0, "R5", overflow, 0);
        do_miss(32'h28);
        check(overflow == 1'b1, "R5", overflow, 1);
        check(sample_addr == 32'h18, "R3", sample_addr, 32'h18);
        check(irq == 1'b1, "R5", irq, 1);
        ack();
        check(irq == 1'b0 && overflow == 1'b0, "R4", {irq, overflow}, 0);

        // R6 sample and ack in the same cycle
        set_period('0);
        set_period(32'd2);
        do_miss(32'h100);
        do_miss(32'h104);
        check(irq == 1'b1, "R6", irq, 1);
        do_miss(32'h108);
        do_miss(32'h10C);
        check(overflow == 1'b1, "R6", overflow, 1);
        do_miss(32'h110);
        miss_with_ack(32'h114);
        check(irq == 1'b1, "R6", irq, 1);
        check(sample_addr == 32'h114, "R6", sample_addr, 32'h114);
        check(overflow == 1'b0, "R6", overflow, 0);

        // R7 disabling drops a pending interrupt and blocks new ones
        set_period('0);
        check(irq == 1'b0 && overflow == 1'b0, "R7", {irq, overflow}, 0);
        for (int i = 0; i < 10; i++) do_miss(32'h200 + i);
        check(irq == 1'b0, "R7", irq, 0);
        set_period(32'd4);
        for (int i = 1; i <= 4; i++) begin
            do_miss(32'h300 + i);
            check(irq == (i == 4), "R7", irq, (i == 4));
        end
        ack();

        // R8 jitter width 0: exact period
        cfg_jitter_en = 1'b1;
        cfg_jitter_bits = 5'd0;
        set_period('0);
        set_period(32'd20);
        cnt = 0;
        for (int s = 0; s < 5; s++) begin
            cnt = 0;
            do begin
                do_miss(32'h400);
                cnt++;
            end while (!irq && cnt < 100);
            check(cnt == 20, "R8", cnt, 20);
            ack();
        end

        // R8 jitter width 3: intervals in [20,27] and varying
        cfg_jitter_bits = 5'd3;
        set_period('0);
        set_period(32'd20);
        mn = 1000;
        mx = 0;
        for (int s = 0; s < 30; s++) begin
            cnt = 0;
            do begin
                do_miss(32'h500);
                cnt++;
            end while (!irq && cnt < 100);
            check(cnt >= 20 && cnt <= 27, "R8", cnt, 20);
            if (cnt < mn) mn = cnt;
            if (cnt > mx) mx = cnt;
            ack();
        end
        check(mx > mn, "R8", mx, mn + 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule